// File: doc/BRIEF.md
# Configuration list copy sequencer

The sequencer moves groups of configuration bytes between a nonvolatile store model and the live register file of a chip. Which registers move is decided by a short descriptor list held in a separate segment buffer. A group entry names a count and a 16-bit start register. Two single-byte codes are also allowed. One asks for a register-update strobe. The other closes the list.

A load copies from the store into the registers. A load starts by itself when reset is released, and can also be started by a soft request. A store copies from the registers into the store. Its pending flag clears itself when the copy finishes. Store bytes are packed one after another from store address 0, in list order. A load reads them back in the same order. Every run ends with a one-cycle done pulse. A sticky error flag reports a bad list.

All three memories are simple synchronous ports. Read data appears one cycle after the address. A write takes effect at the clock edge where the write enable is high.

Top module: `cfg_copy_seq`

## Requirements
- R1: A group entry is three list bytes. The first is a byte with bit 7 clear, holding k in bits [6:0]. The second is start address bits [15:8] and the third is bits [7:0]. In a load, this entry copies k+1 bytes from consecutive store addresses into consecutive registers from the start address upward. The first store address of a run is 0.
- R2: In a store run, the same list copies each group's registers into the store. Store addresses start at 0 and run on across groups, in list order.
- R3: In a load, the list byte 0x80 makes update_o high for exactly one cycle, the cycle after that byte is decoded. In a store, 0x80 is skipped and gives no strobe.
- R4: The list byte 0xFF ends the run. In the next cycle busy_o is low and done_o is high for one cycle. Each list byte takes two cycles and each copied byte takes two cycles.
- R5: A list byte in the opcode position with bit 7 set, other than 0x80 or 0xFF, ends the run with err_o set.
- R6: Suppose the list pointer reaches SEG_DEPTH before 0xFF is seen. The run then ends with err_o set, one cycle after that fetch.
- R7: busy_o rises in the cycle after an accepted request. It stays high until the run ends. Requests that arrive while busy_o is high are ignored.
- R8: If load_req_i and store_req_i are high in the same idle cycle, a load is started.
- R9: store_pend_o rises with an accepted store request and clears in the cycle in which done_o pulses.
- R10: Leaving reset starts a load: busy_o is high during reset and the list is processed from index 0.
- R11: err_o holds its value while idle. It is cleared when the next run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_req_i | input | 1 | Soft load request |
| store_req_i | input | 1 | Store request |
| seg_addr_o | output | SEG_AW | Segment buffer read address |
| seg_rdata_i | input | 8 | Segment read data, one cycle latency |
| nv_addr_o | output | NV_AW | Store address |
| nv_we_o | output | 1 | Store write enable |
| nv_wdata_o | output | 8 | Store write data |
| nv_rdata_i | input | 8 | Store read data, one cycle latency |
| rf_addr_o | output | 16 | Register file address |
| rf_we_o | output | 1 | Register file write enable |
| rf_wdata_o | output | 8 | Register file write data |
| rf_rdata_i | input | 8 | Register file read data, one cycle latency |
| update_o | output | 1 | Register-update strobe |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Sticky transfer error |
| store_pend_o | output | 1 | Self-clearing store request flag |

## Verification
A wrong list pointer or field phase would misread the list at once. The symptom is a shifted update pulse, a busy_o that is longer or shorter than expected, or a wrong error flag. Any of these shows up in the first cycle that differs, because the bench predicts all five status outputs for every cycle. A wrong address or byte counter shows no status symptom. It is caught at the end of the run, when every store byte and every touched register is compared with the model's copy.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  localparam logic [7:0] OPC_UPDATE = 8'h80;
  localparam logic [7:0] OPC_END    = 8'hFF;

  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_DECODE, ST_RD, ST_WR} seq_st_e;
  typedef enum logic [1:0] {FLD_OP, FLD_AHI, FLD_ALO} seq_fld_e;
  typedef enum logic {DIR_LOAD, DIR_STORE} seq_dir_e;
endpackage

// File: rtl/cfg_seq_start.sv
module cfg_seq_start
  import cfg_seq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     idle_i,
  input  logic     load_req_i,
  input  logic     store_req_i,
  output logic     start_o,
  output seq_dir_e dir_o
);
  assign start_o = idle_i && (load_req_i || store_req_i);
  assign dir_o   = load_req_i ? DIR_LOAD : DIR_STORE;

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && load_req_i) |-> (dir_o == DIR_LOAD)); // R8
  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |-> !start_o); // R7
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int SEG_DEPTH = 16,
  parameter int NV_AW     = 8,
  parameter int RA_W      = 16,
  parameter bit BOOT_LOAD = 1'b1,
  localparam int SEG_AW   = $clog2(SEG_DEPTH),
  localparam int PTR_W    = $clog2(SEG_DEPTH + 1),
  localparam int CNT_W    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  seq_dir_e          start_dir_i,
  input  logic [7:0]        seg_rdata_i,
  output logic [SEG_AW-1:0] seg_addr_o,
  output logic [RA_W-1:0]   reg_addr_o,
  output logic [NV_AW-1:0]  nv_addr_o,
  output logic              wr_en_o,
  output seq_dir_e          dir_o,
  output logic              idle_o,
  output logic              update_o,
  output logic              done_o,
  output logic              err_o,
  output logic              store_pend_o
);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(SEG_DEPTH);

  seq_st_e           state_q;
  seq_fld_e          fld_q;
  seq_dir_e          dir_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [CNT_W-1:0]  remain_q;
  logic [RA_W-1:0]   raddr_q;
  logic [NV_AW-1:0]  nvaddr_q;
  logic              upd_q, done_q, err_q, spend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= BOOT_LOAD ? ST_FETCH : ST_IDLE;
      fld_q    <= FLD_OP;
      dir_q    <= DIR_LOAD;
      ptr_q    <= '0;
      remain_q <= '0;
      raddr_q  <= '0;
      nvaddr_q <= '0;
      upd_q    <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      spend_q  <= 1'b0;
    end else begin
      upd_q  <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q  <= ST_FETCH;
            fld_q    <= FLD_OP;
            dir_q    <= start_dir_i;
            ptr_q    <= '0;
            nvaddr_q <= '0;
            err_q    <= 1'b0;
            spend_q  <= (start_dir_i == DIR_STORE);
          end
        end
        ST_FETCH: begin
          if (ptr_q == PTR_END) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            spend_q <= 1'b0;
          end else begin
            state_q <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          unique case (fld_q)
            FLD_OP: begin
              if (seg_rdata_i == OPC_END || (seg_rdata_i[7] && seg_rdata_i != OPC_UPDATE)) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
                err_q   <= (seg_rdata_i != OPC_END);
                spend_q <= 1'b0;
              end else if (seg_rdata_i == OPC_UPDATE) begin
                upd_q   <= (dir_q == DIR_LOAD);
                ptr_q   <= ptr_q + 1'b1;
                state_q <= ST_FETCH;
              end else begin
                remain_q <= seg_rdata_i[CNT_W-1:0];
                fld_q    <= FLD_AHI;
                ptr_q    <= ptr_q + 1'b1;
                state_q  <= ST_FETCH;
              end
            end
            FLD_AHI: begin
              raddr_q[RA_W-1:RA_W-8] <= seg_rdata_i;
              fld_q   <= FLD_ALO;
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_FETCH;
            end
            default: begin
              raddr_q[7:0] <= seg_rdata_i;
              fld_q   <= FLD_OP;
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_RD;
            end
          endcase
        end
        ST_RD: state_q <= ST_WR;
        ST_WR: begin
          raddr_q  <= raddr_q + 1'b1;
          nvaddr_q <= nvaddr_q + 1'b1;
          if (remain_q == '0) begin
            state_q <= ST_FETCH;
          end else begin
            remain_q <= remain_q - 1'b1;
            state_q  <= ST_RD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign seg_addr_o   = ptr_q[SEG_AW-1:0];
  assign reg_addr_o   = raddr_q;
  assign nv_addr_o    = nvaddr_q;
  assign wr_en_o      = (state_q == ST_WR);
  assign dir_o        = dir_q;
  assign idle_o       = (state_q == ST_IDLE);
  assign update_o     = upd_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign store_pend_o = spend_q;

  AST_UPD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |=> !upd_q); // R3
  AST_UPD_LOAD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> (dir_q == DIR_LOAD)); // R3
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_IDLE)); // R4
  AST_PTR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PTR_END); // R6
  AST_PEND_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spend_q) |-> done_q); // R9
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && $past(state_q == ST_IDLE)) |-> $stable(err_q)); // R11
endmodule

// File: rtl/cfg_seq_steer.sv
module cfg_seq_steer
  import cfg_seq_pkg::*;
(
  input  seq_dir_e   dir_i,
  input  logic       wr_en_i,
  input  logic [7:0] nv_rdata_i,
  input  logic [7:0] rf_rdata_i,
  output logic       nv_we_o,
  output logic       rf_we_o,
  output logic [7:0] nv_wdata_o,
  output logic [7:0] rf_wdata_o
);
  assign rf_we_o    = wr_en_i && (dir_i == DIR_LOAD);
  assign nv_we_o    = wr_en_i && (dir_i == DIR_STORE);
  assign rf_wdata_o = nv_rdata_i;
  assign nv_wdata_o = rf_rdata_i;
endmodule

// File: rtl/cfg_copy_seq.sv
module cfg_copy_seq
  import cfg_seq_pkg::*;
#(
  parameter int SEG_DEPTH = 16,
  parameter int NV_AW     = 8,
  parameter bit BOOT_LOAD = 1'b1,
  localparam int SEG_AW   = $clog2(SEG_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_req_i,
  input  logic              store_req_i,
  output logic [SEG_AW-1:0] seg_addr_o,
  input  logic [7:0]        seg_rdata_i,
  output logic [NV_AW-1:0]  nv_addr_o,
  output logic              nv_we_o,
  output logic [7:0]        nv_wdata_o,
  input  logic [7:0]        nv_rdata_i,
  output logic [15:0]       rf_addr_o,
  output logic              rf_we_o,
  output logic [7:0]        rf_wdata_o,
  input  logic [7:0]        rf_rdata_i,
  output logic              update_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              store_pend_o
);
  logic     idle, start, wr_en;
  seq_dir_e start_dir, dir;

  cfg_seq_start i_start (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idle_i     (idle),
    .load_req_i (load_req_i),
    .store_req_i(store_req_i),
    .start_o    (start),
    .dir_o      (start_dir)
  );

  cfg_seq_ctrl #(
    .SEG_DEPTH(SEG_DEPTH),
    .NV_AW    (NV_AW),
    .RA_W     (16),
    .BOOT_LOAD(BOOT_LOAD)
  ) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .start_dir_i (start_dir),
    .seg_rdata_i (seg_rdata_i),
    .seg_addr_o  (seg_addr_o),
    .reg_addr_o  (rf_addr_o),
    .nv_addr_o   (nv_addr_o),
    .wr_en_o     (wr_en),
    .dir_o       (dir),
    .idle_o      (idle),
    .update_o    (update_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .store_pend_o(store_pend_o)
  );

  cfg_seq_steer i_steer (
    .dir_i     (dir),
    .wr_en_i   (wr_en),
    .nv_rdata_i(nv_rdata_i),
    .rf_rdata_i(rf_rdata_i),
    .nv_we_o   (nv_we_o),
    .rf_we_o   (rf_we_o),
    .nv_wdata_o(nv_wdata_o),
    .rf_wdata_o(rf_wdata_o)
  );

  assign busy_o = !idle;

  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R4
  AST_ONE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nv_we_o && rf_we_o)); // R2
endmodule

// File: tb/test_cfg_copy_seq.sv
module test_cfg_copy_seq;
  localparam int SEG_DEPTH = 16;
  localparam int SEG_AW    = 4;
  localparam int NV_AW     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic load_req = 1'b0, store_req = 1'b0;
  logic [SEG_AW-1:0] seg_addr;
  logic [7:0] seg_rdata = '0, nv_rdata = '0, rf_rdata = '0;
  logic [NV_AW-1:0] nv_addr;
  logic nv_we, rf_we, update, busy, done, err, store_pend;
  logic [7:0] nv_wdata, rf_wdata;
  logic [15:0] rf_addr;

  cfg_copy_seq #(.SEG_DEPTH(SEG_DEPTH), .NV_AW(NV_AW), .BOOT_LOAD(1'b1)) i_cfg_copy_seq (
    .clk_i(clk), .rst_ni(rst_n), .load_req_i(load_req), .store_req_i(store_req),
    .seg_addr_o(seg_addr), .seg_rdata_i(seg_rdata),
    .nv_addr_o(nv_addr), .nv_we_o(nv_we), .nv_wdata_o(nv_wdata), .nv_rdata_i(nv_rdata),
    .rf_addr_o(rf_addr), .rf_we_o(rf_we), .rf_wdata_o(rf_wdata), .rf_rdata_i(rf_rdata),
    .update_o(update), .busy_o(busy), .done_o(done), .err_o(err), .store_pend_o(store_pend)
  );

  logic [7:0] seg [SEG_DEPTH];
  logic [7:0] nv [256];
  logic [7:0] m_nv [256];
  logic [7:0] rf_mem [logic [15:0]];
  logic [7:0] m_rf [logic [15:0]];

  function automatic logic [7:0] rf_init(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] rf_get(logic [15:0] a);
    if (rf_mem.exists(a)) return rf_mem[a];
    return rf_init(a);
  endfunction
  function automatic logic [7:0] m_get(logic [15:0] a);
    if (m_rf.exists(a)) return m_rf[a];
    return rf_init(a);
  endfunction

  always @(posedge clk) begin
    seg_rdata <= seg[seg_addr];
    nv_rdata  <= nv[nv_addr];
    rf_rdata  <= rf_get(rf_addr);
    if (nv_we) nv[nv_addr] <= nv_wdata;
    if (rf_we) rf_mem[rf_addr] = rf_wdata;
  end

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit chk_on = 1'b0;
  logic last_err = 1'b0;
  string busy_tag = "R7", err_tag = "R5", sp_tag = "R9";
  logic [4:0] exp_q [$];  // {busy, upd, done, err, sp}

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic void push(logic b, logic u, logic d, logic e, logic s);
    exp_q.push_back({b, u, d, e, s});
  endfunction

  // behavioural model: expected per-cycle status and memory effect
  function automatic void build(bit st);
    int p = 0;
    int nvp = 0;
    int cnt;
    logic [15:0] a;
    logic [7:0] b;
    push(1, 0, 0, 0, st);
    forever begin
      if (p == SEG_DEPTH) begin push(0, 0, 1, 1, 0); return; end
      push(1, 0, 0, 0, st);
      b = seg[p];
      if (b == 8'hFF) begin push(0, 0, 1, 0, 0); return; end
      if (b == 8'h80) begin p++; push(1, !st, 0, 0, st); continue; end
      if (b[7]) begin push(0, 0, 1, 1, 0); return; end
      cnt = int'(b) + 1;
      p++;
      push(1, 0, 0, 0, st);
      if (p == SEG_DEPTH) begin push(0, 0, 1, 1, 0); return; end
      push(1, 0, 0, 0, st);
      a[15:8] = seg[p];
      p++;
      push(1, 0, 0, 0, st);
      if (p == SEG_DEPTH) begin push(0, 0, 1, 1, 0); return; end
      push(1, 0, 0, 0, st);
      a[7:0] = seg[p];
      p++;
      for (int i = 0; i < cnt; i++) begin
        push(1, 0, 0, 0, st);
        push(1, 0, 0, 0, st);
        if (st) m_nv[nvp] = m_get(a);
        else m_rf[a] = m_nv[nvp];
        a = a + 16'd1;
        nvp = (nvp + 1) % 256;
      end
      push(1, 0, 0, 0, st);
    end
  endfunction

  always @(negedge clk) begin
    if (chk_on) begin
      logic [4:0] e;
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else e = {1'b0, 1'b0, 1'b0, last_err, 1'b0};
      if (e[2]) last_err = e[1];
      chk(busy_tag, {7'd0, busy}, {7'd0, e[4]}, "busy");
      chk("R3", {7'd0, update}, {7'd0, e[3]}, "update");
      chk("R4", {7'd0, done}, {7'd0, e[2]}, "done");
      chk(err_tag, {7'd0, err}, {7'd0, e[1]}, "err");
      chk(sp_tag, {7'd0, store_pend}, {7'd0, e[0]}, "store_pend");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      summary();
    end
  end

  task automatic req(logic l, logic s);
    @(negedge clk); #1;
    load_req = l;
    store_req = s;
    build(s && !l);
    @(negedge clk); #1;
    load_req = 1'b0;
    store_req = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic mem_chk(string tag);
    #2;
    for (int i = 0; i < 256; i++) chk(tag, nv[i], m_nv[i], "store byte");
    foreach (m_rf[k]) chk(tag, rf_get(k), m_rf[k], "register");
  endtask

  task automatic list_a();
    // group of 3 at 0x0010, update, group of 1 at 0x1234, end
    seg[0] = 8'h02; seg[1] = 8'h00; seg[2] = 8'h10; seg[3] = 8'h80;
    seg[4] = 8'h00; seg[5] = 8'h12; seg[6] = 8'h34; seg[7] = 8'hFF;
  endtask

  initial begin
    for (int i = 0; i < SEG_DEPTH; i++) seg[i] = 8'hFF;
    for (int i = 0; i < 256; i++) begin
      nv[i] = 8'(i * 3 + 1);
      m_nv[i] = nv[i];
    end
    list_a();
    busy_tag = "R10";
    build(1'b0);
    void'(exp_q.pop_front());
    @(negedge clk);
    chk("R10", {7'd0, busy}, 8'd1, "reset busy");
    chk("R10", {7'd0, done}, 8'd0, "reset done");
    chk("R10", {7'd0, err}, 8'd0, "reset err");
    chk("R10", {7'd0, update}, 8'd0, "reset update");
    #5;
    rst_n = 1'b1;
    chk_on = 1'b1;
    wait_idle();
    busy_tag = "R7";
    mem_chk("R1");

    // store with new register values; a load request mid-run is ignored (R7)
    rf_mem[16'h0010] = 8'hA1; m_rf[16'h0010] = 8'hA1;
    rf_mem[16'h0011] = 8'hB2; m_rf[16'h0011] = 8'hB2;
    rf_mem[16'h0012] = 8'hC3; m_rf[16'h0012] = 8'hC3;
    rf_mem[16'h1234] = 8'hD4; m_rf[16'h1234] = 8'hD4;
    req(1'b0, 1'b1);
    repeat (4) @(negedge clk);
    #1 load_req = 1'b1;
    @(negedge clk);
    #1 load_req = 1'b0;
    wait_idle();
    mem_chk("R2");

    // simultaneous requests: load wins
    rf_mem[16'h0011] = 8'h00; m_rf[16'h0011] = 8'h00;
    sp_tag = "R8";
    req(1'b1, 1'b1);
    wait_idle();
    mem_chk("R8");
    sp_tag = "R9";

    // reserved opcode byte
    seg[0] = 8'h81;
    err_tag = "R5";
    req(1'b1, 1'b0);
    wait_idle();

    // next run clears the error
    list_a();
    err_tag = "R11";
    req(1'b1, 1'b0);
    wait_idle();
    mem_chk("R1");

    // list without end code overruns the segment
    for (int i = 0; i < SEG_DEPTH; i++) seg[i] = 8'h80;
    err_tag = "R6";
    req(1'b1, 1'b0);
    wait_idle();

    // overrun inside a group descriptor
    for (int i = 0; i < SEG_DEPTH; i++) seg[i] = 8'h80;
    seg[14] = 8'h01; seg[15] = 8'h00;
    req(1'b0, 1'b1);
    wait_idle();

    summary();
  end
endmodule